// File: doc/BRIEF.md
# Memory Client Hot-Reset Flush Controller

Before a power partition is switched off, every memory-bus client that lives inside it has to be quiesced. This controller walks a small per-partition client table and does the work in hardware. On a flush command it raises one client's hot-reset request, waits until that client's acknowledge comes back, then moves on to the next client. When the list is exhausted it pulses `done`. On a release command it drops the request of every listed client, one per cycle, without waiting for anything.

The table is a parameter. Each partition owns `LIST_MAX` 8-bit slots, and any slot code of `N_CLIENTS` or above (the marker 8'hFF is the normal choice) ends that partition's list early. Acknowledges are not looked at continuously. They are sampled once every `POLL_CYCLES` clocks, which mirrors a fixed polling interval. Request bits belonging to other partitions are never disturbed, so several partitions can be held in hot reset at the same time.

Top module: `mc_hotreset_flush`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), `hr_req` is all zero and `done` and `busy` are low.
- R2: While `busy` is low, a `cmd_valid` with `cmd_release`=0 is accepted at the clock edge, `busy` is high from the next cycle, and a completed flush leaves the request bit of every listed client set.
- R3: Clients are flushed strictly in slot order (slot 0 first). The request of a slot is raised only after the acknowledge of the previous slot was accepted, and at most one request bit rises per cycle.
- R4: A client's acknowledge is sampled `POLL_CYCLES` edges after its request rises, and again every `POLL_CYCLES` edges until it is seen high. With the acknowledge already high, a one-client flush pulses `done` in the cycle following edge E0+`POLL_CYCLES`+2, where E0 is the accept edge.
- R5: `done` is a single-cycle pulse with `busy` low in the same cycle. An empty partition (slot 0 holds an end code) pulses `done` after edge E0+1 and changes no request bit.
- R6: A slot code of `N_CLIENTS` or above ends the list; the slots after it are never requested, even if they hold valid client codes.
- R7: A release (`cmd_release`=1) clears the listed clients' bits one per cycle in slot order without sampling acknowledges. For n listed clients, `done` pulses after edge E0+n+1.
- R8: Bits of clients that are not in the commanded partition keep their value through both flush and release, and `hr_req` does not change while `busy` is low.
- R9: A `cmd_valid` that arrives while `busy` is high is ignored.
- R10: A partition index of `N_PARTS` or above behaves as an empty list: `done` pulses after edge E0+1 and no request bit changes.
- R11: A partition whose list fills all `LIST_MAX` slots flushes all of them and then finishes, without reading past the last slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, taken only while idle |
| cmd_release | input | 1 | 0 = flush, 1 = release |
| cmd_part | input | PART_IDX_W | Partition index |
| hr_ack | input | N_CLIENTS | Per-client hot-reset acknowledge |
| hr_req | output | N_CLIENTS | Per-client hot-reset request |
| busy | output | 1 | A command is being executed |
| done | output | 1 | One-cycle completion pulse |

## Verification
Several properties are checked on every cycle: that `done` is a lone pulse raised while idle and right after a busy cycle, that no more than one request bit rises in any cycle, and that the request vector stays frozen whenever the controller is idle. The remaining behaviour depends on the table contents and on acknowledge timing, so only the bench scenarios can show it. That covers the slot ordering across three clients with uneven acknowledge delays, the poll spacing, early termination at an end code with a valid code behind it, an out-of-range partition, a command dropped mid-flush, and the exact cycle counts of release and empty-list completion.

// File: rtl/hrf_pkg.sv
// Package: shared types and constants for the hot-reset flush controller.
// Assumes table entries are ENTRY_W bits wide; codes >= client count end a list.
package hrf_pkg;

    localparam int ENTRY_W = 8;
    localparam logic [ENTRY_W-1:0] END_MARK = 8'hFF;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_STEP  = 2'd1,
        ST_POLL  = 2'd2,
        ST_CLEAR = 2'd3
    } hrf_state_e;

endpackage

// File: rtl/hrf_list_sel.sv
// Module: selects one slot of one partition from the parameter table and
// reports whether that slot ends the list.
// Assumes: PART_TABLE holds N_PARTS rows of LIST_MAX entries, slot 0 of
// partition p at bit offset (p*LIST_MAX)*ENTRY_W. Purely combinational.
module hrf_list_sel
    import hrf_pkg::*;
#(
    parameter int N_CLIENTS  = 18,
    parameter int N_PARTS    = 6,
    parameter int LIST_MAX   = 3,
    parameter int PART_IDX_W = 3,
    parameter int SLOT_W     = 2,
    parameter int CLI_W      = 5,
    parameter logic [N_PARTS*LIST_MAX*ENTRY_W-1:0] PART_TABLE = '1
) (
    input  logic [PART_IDX_W-1:0] part,
    input  logic [SLOT_W-1:0]     slot,
    output logic [CLI_W-1:0]      client,
    output logic                  at_end
);

    logic [ENTRY_W-1:0] entry;

    // Look up the table entry for (part, slot); out-of-range indices give END_MARK.
    always_comb begin
        entry = END_MARK;
        for (int p = 0; p < N_PARTS; p++) begin
            for (int s = 0; s < LIST_MAX; s++) begin
                if (int'(part) == p && int'(slot) == s) begin
                    entry = PART_TABLE[(p*LIST_MAX+s)*ENTRY_W +: ENTRY_W];
                end
            end
        end
    end

    // Classify the entry and narrow it to a client index.
    always_comb begin
        at_end = (int'(entry) >= N_CLIENTS);
        client = entry[CLI_W-1:0];
    end

endmodule

// File: rtl/hrf_poll_timer.sv
// Module: poll interval counter. A load restarts the interval; `expired`
// is high when the interval has elapsed and the acknowledge may be sampled.
// Assumes POLL_CYCLES >= 1.
module hrf_poll_timer #(
    parameter int POLL_CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);

    localparam int CNT_W = (POLL_CYCLES > 1) ? $clog2(POLL_CYCLES) : 1;
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(POLL_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    // Reload on request, otherwise count down and hold at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= RELOAD;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/hrf_req_bank.sv
// Module: per-client request flops. Each bit is set or cleared only when it
// is addressed, so every other client's bit keeps its value.
// Assumes set_en and clr_en are never high together.
module hrf_req_bank #(
    parameter int N_CLIENTS = 18,
    parameter int CLI_W     = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 set_en,
    input  logic                 clr_en,
    input  logic [CLI_W-1:0]     idx,
    output logic [N_CLIENTS-1:0] req
);

    for (genvar i = 0; i < N_CLIENTS; i++) begin : g_bit
        logic bit_q;
        logic hit;

        assign hit = (int'(idx) == i);

        // Update this client's request bit when it is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bit_q <= 1'b0;
            end else if (set_en && hit) begin
                bit_q <= 1'b1;
            end else if (clr_en && hit) begin
                bit_q <= 1'b0;
            end
        end

        assign req[i] = bit_q;
    end

endmodule

// File: rtl/mc_hotreset_flush.sv
// Module: memory client hot-reset flush controller (top).
// Flush: for each listed client in slot order, raise its request, then
// sample its acknowledge every POLL_CYCLES clocks until it is high.
// Release: drop each listed request, one per cycle, without waiting.
// Assumes hr_ack is synchronous to clk. Commands arriving while busy are dropped.
module mc_hotreset_flush
    import hrf_pkg::*;
#(
    parameter int N_CLIENTS   = 18,
    parameter int N_PARTS     = 6,
    parameter int LIST_MAX    = 3,
    parameter int PART_IDX_W  = 3,
    parameter int POLL_CYCLES = 2000,
    parameter logic [N_PARTS*LIST_MAX*ENTRY_W-1:0] PART_TABLE =
        144'hFFFF10_060405_FF1108_03FF00_FFFF0C_FFFFFF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_valid,
    input  logic                  cmd_release,
    input  logic [PART_IDX_W-1:0] cmd_part,
    input  logic [N_CLIENTS-1:0]  hr_ack,
    output logic [N_CLIENTS-1:0]  hr_req,
    output logic                  busy,
    output logic                  done
);

    localparam int SLOT_W = $clog2(LIST_MAX + 1);
    localparam int CLI_W  = (N_CLIENTS > 1) ? $clog2(N_CLIENTS) : 1;

    hrf_state_e             state_q;
    logic [PART_IDX_W-1:0]  part_q;
    logic [SLOT_W-1:0]      slot_q;
    logic                   done_q;

    logic [CLI_W-1:0]       client;
    logic                   at_end;
    logic                   expired;
    logic                   ack_sel;
    logic                   set_en;
    logic                   clr_en;
    logic                   load;

    hrf_list_sel #(
        .N_CLIENTS  (N_CLIENTS),
        .N_PARTS    (N_PARTS),
        .LIST_MAX   (LIST_MAX),
        .PART_IDX_W (PART_IDX_W),
        .SLOT_W     (SLOT_W),
        .CLI_W      (CLI_W),
        .PART_TABLE (PART_TABLE)
    ) u_list (
        .part   (part_q),
        .slot   (slot_q),
        .client (client),
        .at_end (at_end)
    );

    hrf_poll_timer #(
        .POLL_CYCLES (POLL_CYCLES)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .expired (expired)
    );

    hrf_req_bank #(
        .N_CLIENTS (N_CLIENTS),
        .CLI_W     (CLI_W)
    ) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (set_en),
        .clr_en (clr_en),
        .idx    (client),
        .req    (hr_req)
    );

    // Pick the acknowledge of the client currently being flushed.
    always_comb begin
        ack_sel = 1'b0;
        for (int i = 0; i < N_CLIENTS; i++) begin
            if (int'(client) == i) begin
                ack_sel = hr_ack[i];
            end
        end
    end

    // Derive the request bank strobes and the poll timer reload.
    always_comb begin
        set_en = (state_q == ST_STEP)  && !at_end;
        clr_en = (state_q == ST_CLEAR) && !at_end;
        load   = set_en || ((state_q == ST_POLL) && expired && !ack_sel);
    end

    // Sequence the command through the partition's slots.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            part_q  <= '0;
            slot_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        part_q  <= cmd_part;
                        slot_q  <= '0;
                        state_q <= cmd_release ? ST_CLEAR : ST_STEP;
                    end
                end
                ST_STEP: begin
                    if (at_end) begin
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end else begin
                        state_q <= ST_POLL;
                    end
                end
                ST_POLL: begin
                    if (expired && ack_sel) begin
                        slot_q  <= slot_q + SLOT_W'(1);
                        state_q <= ST_STEP;
                    end
                end
                ST_CLEAR: begin
                    if (at_end) begin
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end else begin
                        slot_q <= slot_q + SLOT_W'(1);
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state_q != ST_IDLE);
    assign done = done_q;

endmodule

// File: rtl/hrf_checker.sv
// Module: protocol checker for mc_hotreset_flush, attached by bind.
// Assumes synchronous active-low reset; history registers restart at reset.
module hrf_checker #(
    parameter int N_CLIENTS = 18
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 busy,
    input logic                 done,
    input logic [N_CLIENTS-1:0] hr_req
);

    logic                 busy_prev;
    logic [N_CLIENTS-1:0] req_prev;

    // Keep one cycle of history, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_prev <= 1'b0;
            req_prev  <= '0;
        end else begin
            busy_prev <= busy;
            req_prev  <= hr_req;
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                              // R5
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);                                              // R5
    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy_prev);                                          // R2
    AST_ONE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(hr_req & ~req_prev) <= 1);                         // R3
    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(hr_req));                                   // R8

endmodule

bind mc_hotreset_flush hrf_checker #(.N_CLIENTS(N_CLIENTS)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .busy   (busy),
    .done   (done),
    .hr_req (hr_req)
);

// File: tb/mc_hotreset_flush_tb.sv
module mc_hotreset_flush_tb;

    localparam int NC   = 18;
    localparam int POLL = 5;

    typedef int list_t[$];

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_release = 1'b0;
    logic [2:0]    cmd_part = '0;
    logic [NC-1:0] hr_ack;
    logic [NC-1:0] hr_req;
    logic          busy;
    logic          done;

    logic [NC-1:0] ack_force = '0;
    logic [NC-1:0] ack_resp  = '0;
    int            dly [NC];
    int            held [NC];
    int            rise_at [NC];
    int            cyc = 0;

    int total = 0;
    int bad   = 0;
    bit started = 0;
    bit finished = 0;

    assign hr_ack = ack_resp | ack_force;

    always #2.5 clk = ~clk;

    mc_hotreset_flush #(.POLL_CYCLES(POLL)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_release(cmd_release),
        .cmd_part(cmd_part), .hr_ack(hr_ack), .hr_req(hr_req), .busy(busy), .done(done)
    );

    // Partition lists as the requirements define them.
    function automatic list_t part_list(input int p);
        list_t q;
        case (p)
            1: q = '{12};
            2: q = '{0};
            3: q = '{8, 17};
            4: q = '{5, 4, 6};
            5: q = '{16};
            default: q = '{};
        endcase
        return q;
    endfunction

    // Reference model state.
    int            m_st = 0;
    list_t         m_list;
    int            m_pos = 0;
    int            m_cnt = 0;
    logic [NC-1:0] m_req = '0;
    bit            m_done = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_pos = 0; m_cnt = 0; m_req = '0; m_done = 0;
        end else begin
            m_done = 0;
            case (m_st)
                0: if (cmd_valid) begin
                       m_list = part_list(int'(cmd_part));
                       m_pos = 0;
                       m_st = cmd_release ? 3 : 1;
                   end
                1: if (m_pos >= m_list.size()) begin m_done = 1; m_st = 0; end
                   else begin m_req[m_list[m_pos]] = 1'b1; m_cnt = POLL - 1; m_st = 2; end
                2: if (m_cnt > 0) m_cnt--;
                   else if (hr_ack[m_list[m_pos]]) begin m_pos++; m_st = 1; end
                   else m_cnt = POLL - 1;
                default: if (m_pos >= m_list.size()) begin m_done = 1; m_st = 0; end
                   else begin m_req[m_list[m_pos]] = 1'b0; m_pos++; end
            endcase
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Acknowledge responder and per-cycle comparison against the model.
    always @(negedge clk) begin
        cyc++;
        for (int c = 0; c < NC; c++) begin
            if (hr_req[c]) begin
                if (held[c] == 0) rise_at[c] = cyc;
                if (held[c] < 100000) held[c]++;
            end else begin
                held[c] = 0;
            end
            ack_resp[c] = hr_req[c] && (held[c] > dly[c]);
        end
        if (started) begin
            check(hr_req === m_req, "R3 hr_req vs model", longint'(hr_req), longint'(m_req));
            check(done === m_done, "R5 done vs model", longint'(done), longint'(m_done));
            check(busy === (m_st != 0), "R9 busy vs model", longint'(busy), longint'(m_st != 0));
        end
    end

    // Issue one command and count negedges until done is seen.
    task automatic run_cmd(input bit rel, input int part, output int k);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_release = rel; cmd_part = 3'(part);
        @(negedge clk);
        cmd_valid = 1'b0;
        k = 1;
        while (!done && k < 5000) begin
            @(negedge clk);
            k++;
        end
    endtask

    initial begin
        int k;
        logic [NC-1:0] snap;
        for (int c = 0; c < NC; c++) begin dly[c] = 3; held[c] = 0; rise_at[c] = 0; end
        repeat (3) @(negedge clk);
        started = 1;
        check(hr_req == '0 && !done && !busy, "R1 reset state",
              longint'({hr_req, done, busy}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // One client with acknowledge already high: fixed poll latency.
        ack_force[12] = 1'b1;
        run_cmd(0, 1, k);
        check(k == POLL + 3, "R4 pre-acked flush latency", k, POLL + 3);
        check(hr_req == NC'(1 << 12), "R2 flush leaves listed bit set", longint'(hr_req), 1 << 12);
        ack_force[12] = 1'b0;

        // End code before a valid code: slot after it never requested.
        run_cmd(0, 2, k);
        check(hr_req[0] && !hr_req[3], "R6 early end of list", longint'(hr_req), (1 << 12) | 1);

        // Three clients, uneven delays, plus a command dropped while busy.
        dly[5] = 2; dly[4] = 12; dly[6] = 0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_release = 1'b0; cmd_part = 3'd4;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (3) @(negedge clk);
        cmd_valid = 1'b1; cmd_part = 3'd5;
        @(negedge clk);
        cmd_valid = 1'b0;
        k = 0;
        while (!done && k < 5000) begin @(negedge clk); k++; end
        check(hr_req[5] && hr_req[4] && hr_req[6], "R11 all three slots flushed",
              longint'(hr_req), (1 << 12) | (1 << 6) | (1 << 5) | (1 << 4) | 1);
        check(!hr_req[16], "R9 command while busy ignored", hr_req[16], 0);
        check(hr_req[12] && hr_req[0], "R8 other partitions kept", longint'(hr_req),
              (1 << 12) | (1 << 6) | (1 << 5) | (1 << 4) | 1);
        check(rise_at[5] < rise_at[4] && rise_at[4] < rise_at[6], "R3 slot order",
              rise_at[4], rise_at[5] + 1);
        check(rise_at[4] - rise_at[5] >= dly[5] + 2, "R3 next request waits for ack",
              rise_at[4] - rise_at[5], dly[5] + 2);

        // Release of three clients: one per cycle, no ack wait.
        run_cmd(1, 4, k);
        check(k == 5, "R7 release latency", k, 5);
        check(hr_req == NC'((1 << 12) | 1), "R7 release clears listed bits only",
              longint'(hr_req), (1 << 12) | 1);

        // Empty partition.
        snap = hr_req;
        run_cmd(0, 0, k);
        check(k == 2, "R5 empty list done latency", k, 2);
        check(hr_req == snap, "R5 empty list leaves requests", longint'(hr_req), longint'(snap));

        // Out-of-range partition index.
        run_cmd(0, 7, k);
        check(k == 2, "R10 out-of-range partition latency", k, 2);
        check(hr_req == snap, "R10 out-of-range leaves requests", longint'(hr_req), longint'(snap));

        // Release one client while its ack would still be pending.
        run_cmd(1, 1, k);
        check(k == 3, "R7 single release latency", k, 3);
        check(hr_req == NC'(1), "R8 release keeps other bits", longint'(hr_req), 1);

        // Two clients, first one needs several polls.
        dly[8] = 7; dly[17] = 1;
        run_cmd(0, 3, k);
        check(hr_req == NC'((1 << 17) | (1 << 8) | 1), "R2 two-client flush result",
              longint'(hr_req), (1 << 17) | (1 << 8) | 1);

        repeat (4) @(negedge clk);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule